// File: doc/BRIEF.md
# Parallel Self-Synchronous Scrambler (x^58 + x^39 + 1)

This block scrambles a 64-bit data word on every clock in which the input is marked valid. It applies the multiplicative recurrence s[i] = d[i] XOR s[i-39] XOR s[i-58]. Bit 0 of each word is the earliest bit in serial order. The feedback comes from earlier scrambled output bits, not from a free-running sequence generator, so a receiver running the inverse recurrence locks onto the stream by itself once 58 bits have gone by.

A 58-bit history register holds the most recent scrambled bits. For output bits at index 39 and above, the short tap reaches back into bits of the same word that were computed earlier in the word. From index 58 on, the long tap does so as well. The datapath therefore unrolls the recurrence in increasing bit order into one combinational XOR network. The result is registered on the rising edge. A synchronous reset reloads the history with a seed parameter, which is all ones by default.

Top module: `par_scrambler`

## Requirements
- R1: Each output bit equals outData[i] = inData[i] XOR s[i-39] XOR s[i-58]. Bit 0 is earliest in serial order. Negative indices select earlier scrambled bits, including bits of the same word at lower indices.
- R2: All 64 scrambled bits of an accepted word appear together on outData at the first rising clock edge after the edge that accepts the word.
- R3: After an accepted word, history bit k equals outData bit k+6 for k = 0..57, with history bit 0 the oldest. The next word therefore continues the same serial stream.
- R4: While rst is high at a rising edge, outData is cleared to zero, outValid is cleared and the history is loaded with SEED, whatever inValid is. History bit 0 of the seed plays the role of s[-58]. The first word after reset is scrambled from the seed.
- R5: At a rising edge with rst and inValid both low, outData and the history keep their values.
- R6: outValid is 1 in the cycle after an accepted word, and 0 after an idle cycle or a reset cycle.
- R7: Running the inverse recurrence d[i] = s[i] XOR s[i-39] XOR s[i-58] on the output stream, starting from any history, recovers the input data from serial bit 58 onward.
- R8: An instance built with a non-default SEED follows the same recurrence, starting from its own seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, reloads the seed |
| inValid | input | 1 | Accept inData at this edge |
| inData | input | 64 | Plain data word, bit 0 earliest |
| outData | output | 64 | Registered scrambled word |
| outValid | output | 1 | outData holds a word accepted at the previous edge |

## Verification
Every result of this block is due exactly one rising edge after the edge that presents the stimulus. This covers the scrambled word, the valid flag, the cleared outputs after reset and the held word after an idle cycle. The bench drives inputs at the falling edge and samples one nanosecond after the next rising edge. At that same moment its serial bit-by-bit model has advanced by exactly the words accepted so far. History contents are never read directly: they show up in the next accepted word, which the model predicts from its own 58-bit queue.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadSeed;  // reload history, clear output
    logic advance;   // scramble and register a new word
  } scrCtl_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output scrCtl_t ctl,
  output logic    outValid
);
  // Reset wins over a valid word
  always_comb begin
    ctl.loadSeed = rst;
    ctl.advance  = inValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R4
  reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R6
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R6
  idle_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/scr_dp.sv
module scr_dp
  import scr_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int HIST_W    = 58,
  parameter int SHORT_TAP = 39,
  parameter logic [HIST_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  scrCtl_t           ctl,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);
  localparam int EXT_W = HIST_W + DATA_W;

  logic [HIST_W-1:0] hist;
  logic [EXT_W-1:0]  ext;

  // ext[j] is serial bit j-HIST_W: the history sits below, the new word above.
  // Bits are filled in increasing order, so both taps can reach lower
  // bits of the same word.
  always_comb begin
    ext = '0;
    ext[HIST_W-1:0] = hist;
    for (int i = 0; i < DATA_W; i++) begin
      ext[HIST_W+i] = inData[i] ^ ext[HIST_W+i-SHORT_TAP] ^ ext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.loadSeed) begin
      hist    <= SEED;
      outData <= '0;
    end else if (ctl.advance) begin
      hist    <= ext[EXT_W-1 -: HIST_W];
      outData <= ext[EXT_W-1 -: DATA_W];
    end
  end

  // R3
  hist_tracks_output_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> hist == outData[DATA_W-1 -: HIST_W]);

  // R4
  seed_reload_chk: assert property (@(posedge clk)
    ctl.loadSeed |=> (hist == SEED) && (outData == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadSeed && !ctl.advance) |=> $stable(hist) && $stable(outData));
endmodule

// File: rtl/par_scrambler.sv
module par_scrambler
  import scr_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int HIST_W    = 58,
  parameter int SHORT_TAP = 39,
  parameter logic [HIST_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);
  scrCtl_t ctl;

  scr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  scr_dp #(
    .DATA_W    (DATA_W),
    .HIST_W    (HIST_W),
    .SHORT_TAP (SHORT_TAP),
    .SEED      (SEED)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inData  (inData),
    .outData (outData)
  );

  // R5
  idle_output_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outData));
endmodule

// File: tb/sim_par_scrambler.sv
`timescale 1ns/1ps
module sim_par_scrambler;
  localparam logic [57:0] SEED0 = '1;
  localparam logic [57:0] SEED1 = 58'h1234_5678_9ABC_DEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [63:0] outData0, outData1;
  logic outValid0, outValid1;

  always #2 clk = ~clk;  // 250 MHz

  par_scrambler u0 (.clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
                    .outData(outData0), .outValid(outValid0));
  par_scrambler #(.SEED(SEED1)) u1 (.clk(clk), .rst(rst), .inValid(inValid),
                    .inData(inData), .outData(outData1), .outValid(outValid1));

  int checks = 0;
  int errors = 0;
  bit q0[$], q1[$], dq[$];
  logic [63:0] exp0 = '0, exp1 = '0;
  logic expV = 1'b0;
  int streamBits = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic seedQ(ref bit q[$], input logic [57:0] sd);
    q.delete();
    for (int k = 0; k < 58; k++) q.push_back(sd[k]);
  endtask

  // serial model, one bit per step
  task automatic scrWord(ref bit q[$], input logic [63:0] d, output logic [63:0] s);
    for (int i = 0; i < 64; i++) begin
      bit b;
      b = d[i] ^ q[q.size()-39] ^ q[q.size()-58];
      s[i] = b;
      q.push_back(b);
      void'(q.pop_front());
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [63:0] d,
                      input string tag);
    logic [63:0] rec, mask;
    @(negedge clk);
    rst = r; inValid = v; inData = d;
    if (r) begin
      seedQ(q0, SEED0); seedQ(q1, SEED1);
      exp0 = '0; exp1 = '0; expV = 1'b0;
      seedQ(dq, '0); streamBits = 0;
    end else if (v) begin
      scrWord(q0, d, exp0);
      scrWord(q1, d, exp1);
      expV = 1'b1;
    end else begin
      expV = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(outValid0 === expV && outValid1 === expV, r ? "R4" : "R6",
        {62'd0, outValid1, outValid0}, {62'd0, expV, expV});
    chk(outData0 === exp0, tag, outData0, exp0);
    chk(outData1 === exp1, "R8", outData1, exp1);
    if (!r && v) begin
      // inverse recurrence from an all-zero history, not the seed
      rec = '0; mask = '0;
      for (int i = 0; i < 64; i++) begin
        rec[i] = exp0[i] ^ dq[dq.size()-39] ^ dq[dq.size()-58];
        dq.push_back(exp0[i]);
        void'(dq.pop_front());
        if (streamBits + i >= 58) mask[i] = 1'b1;
      end
      streamBits += 64;
      chk(((outData0 ^ outData0) | ((rec ^ d) & mask)) == '0 &&
          outData0 === exp0, "R7", rec & mask, d & mask);
    end
  endtask

  initial begin : watchdog
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [63:0] w;
    // R4: reset state, even with inValid high
    step(1'b1, 1'b0, '0, "R4");
    step(1'b1, 1'b1, 64'hFFFF_0000_FFFF_0000, "R4");
    // R1/R2: zero data exposes the seeded feedback
    step(1'b0, 1'b1, '0, "R2");
    step(1'b0, 1'b1, '0, "R1");
    step(1'b0, 1'b1, '1, "R3");
    // R5: idle cycles hold the output and history
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, "R5");
    step(1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, "R3");
    // R1: single-bit words probe each tap path
    for (int k = 0; k < 64; k += 7) step(1'b0, 1'b1, 64'd1 << k, "R1");
    // random words with gaps
    for (int k = 0; k < 300; k++) begin
      w = {$urandom, $urandom};
      if (k % 5 == 3) step(1'b0, 1'b0, w, "R5");
      else step(1'b0, 1'b1, w, "R3");
    end
    // R4: reset mid-stream reloads the seed
    step(1'b1, 1'b1, '1, "R4");
    for (int k = 0; k < 20; k++) step(1'b0, 1'b1, {$urandom, $urandom}, "R4");
    step(1'b0, 1'b0, '0, "R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule